// File: doc/BRIEF.md
# Host Register Port with Odd Parity

This block is the byte-wide register window that a host processor uses to reach a bus protocol controller. The host selects one of sixteen slots with a 4-bit address, and an active-low chip select qualifies an active-low write strobe and an active-low read strobe. A write is taken into the internal clock domain and committed to the addressed slot when the qualified write strobe is released. A read returns the addressed slot combinationally, together with its stored parity bit, while the block enables its data-bus drivers. Pad tri-states are modelled as enable outputs.

The slot map is a small example set. Slots 0 to SCRATCH_N-1 are full-byte scratch registers. The next slot is a control register whose upper nibble always reads as zero. The slot after that is a read-only identity byte, and the slots above it are unmapped and read as zero. The topmost slot (address 15) holds a fixed preset byte: its write path belongs to a neighbouring unit, so the write decode here never fires for it.

A separate odd-parity generator covers the byte that the host drives on the data bus. Its output enable is off exactly while the block drives the data bus.

Top module: `hostreg_port`

## Requirements
- R1: After reset, slots 0–8 and 10–14 read 0x00, slot 9 reads 0xA5 and slot 15 reads 0x3C. Each reads with its odd parity bit, which is 1 for all of these values.
- R2: Write and read strobes have no effect while cs_n is high. A write pulse does not change any slot, and a read does not raise dout_oe.
- R3: A qualified write (cs_n and wr_n both low) commits once, on the release of the strobe. The new value is first visible on a read sampled after the third rising clock edge following the release and is not visible after the second.
- R4: A write to address 4'b1111 loads no slot. Slot 15 keeps 0x3C and every other slot is unchanged.
- R5: dout_oe is high exactly while cs_n and rd_n are both low. During that time, dout shows the slot selected by addr.
- R6: Writes to the read-only identity slot (9) and to the unmapped slots (10–14) are ignored.
- R7: Bits 7..4 of the control slot (8) always read as 0. Bits 3..0 hold the last value written.
- R8: par_gen equals the odd parity of din (the XNOR of its eight bits). par_gen_oe is the exact inverse of dout_oe, so the two enables are never high together.
- R9: Scratch slots (0–7) return on dout_par the parity bit that was written with the data. The control slot returns the odd parity of the value it reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 4 | Slot address, bit 3 most significant |
| din | input | 8 | Host write data byte |
| din_par | input | 1 | Host write parity bit |
| dout | output | 8 | Read data byte |
| dout_par | output | 1 | Read parity bit |
| dout_oe | output | 1 | Data bus output enable |
| par_gen | output | 1 | Odd parity of din |
| par_gen_oe | output | 1 | Parity generator output enable |

## Verification
Two functions can land in the same cycle: a host read of a slot, and the commit of a write to that same slot. The bench releases the write strobe and lowers the read strobe on the same clock phase, with the address held, so the read stays open across the commit. It requires the old byte after the second rising edge and the new byte after the third. Any extra or missing synchroniser stage, or a commit on the leading edge, changes which sample shows the new value.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int SLOT_N  = 1 << ADDR_W;
    localparam int ENTRY_W = DATA_W + 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  par;
        byte_t data;
    } entry_t;

    function automatic logic odd_par(input byte_t b);
        return ~^b;
    endfunction
endpackage

// File: rtl/hrp_strobe_sync.sv
module hrp_strobe_sync
    import hrp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_n,
    input  logic   wr_n,
    input  addr_t  addr,
    input  byte_t  din,
    input  logic   din_par,
    output logic   commit,
    output addr_t  hold_addr,
    output entry_t hold_entry
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        addr_t                  addr;
        entry_t                 entry;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ~cs_n & ~wr_n};
        st_d.last = st_q.sync[TOP];
        // Track the host bus while the synchronised strobe is still active.
        if (st_q.sync[TOP]) begin
            st_d.addr       = addr;
            st_d.entry.data = din;
            st_d.entry.par  = din_par;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Trailing edge of the qualified strobe.
    assign commit     = st_q.last & ~st_q.sync[TOP];
    assign hold_addr  = st_q.addr;
    assign hold_entry = st_q.entry;
endmodule

// File: rtl/hrp_wr_decode.sv
module hrp_wr_decode
    import hrp_pkg::*;
(
    input  logic              commit,
    input  addr_t             hold_addr,
    output logic [SLOT_N-1:0] we_vec
);
    localparam addr_t EXCL_ADDR = addr_t'(SLOT_N - 1);

    for (genvar i = 0; i < SLOT_N; i++) begin : g_dec
        if (i == SLOT_N - 1) begin : g_excl
            assign we_vec[i] = commit & (hold_addr != EXCL_ADDR) & (hold_addr == addr_t'(i));
        end else begin : g_norm
            assign we_vec[i] = commit & (hold_addr == addr_t'(i));
        end
    end
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile
    import hrp_pkg::*;
#(
    parameter int    SCRATCH_N    = 8,
    parameter byte_t CTRL_MASK    = 8'h0F,
    parameter byte_t ID_VALUE     = 8'hA5,
    parameter byte_t BRIDGE_RESET = 8'h3C
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLOT_N-1:0]         we_vec,
    input  entry_t                    wr_entry,
    input  addr_t                     rd_addr,
    output entry_t                    rd_entry,
    output logic [SLOT_N*ENTRY_W-1:0] store_flat
);
    localparam int CTRL_SLOT = SCRATCH_N;
    localparam int ID_SLOT   = SCRATCH_N + 1;

    entry_t slots [SLOT_N];

    for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
        localparam bit    IS_SCR   = (i < SCRATCH_N);
        localparam bit    IS_CTRL  = (i == CTRL_SLOT);
        localparam bit    IS_ID    = (i == ID_SLOT);
        localparam bit    IS_BRG   = (i == SLOT_N - 1);
        localparam bit    WRITABLE = IS_SCR || IS_CTRL || IS_BRG;
        localparam byte_t KEEP     = (IS_SCR || IS_BRG || IS_ID) ? '1 :
                                     (IS_CTRL ? CTRL_MASK : '0);
        localparam byte_t RST      = IS_ID ? ID_VALUE : (IS_BRG ? BRIDGE_RESET : '0);

        entry_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (WRITABLE && we_vec[i]) begin
                slot_d.data = wr_entry.data & KEEP;
                slot_d.par  = (KEEP == '1) ? wr_entry.par : odd_par(wr_entry.data & KEEP);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q.data <= RST & KEEP;
                slot_q.par  <= odd_par(RST & KEEP);
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slots[i]                          = slot_q;
        assign store_flat[i*ENTRY_W +: ENTRY_W] = slot_q;
    end

    assign rd_entry = slots[rd_addr];
endmodule

// File: rtl/hrp_bus_drive.sv
module hrp_bus_drive
    import hrp_pkg::*;
(
    input  logic   cs_n,
    input  logic   rd_n,
    input  byte_t  din,
    input  entry_t rd_entry,
    output byte_t  dout,
    output logic   dout_par,
    output logic   dout_oe,
    output logic   par_gen,
    output logic   par_gen_oe
);
    logic rd_qual;

    assign rd_qual    = ~cs_n & ~rd_n;
    assign dout       = rd_entry.data;
    assign dout_par   = rd_entry.par;
    assign dout_oe    = rd_qual;
    assign par_gen    = odd_par(din);
    assign par_gen_oe = cs_n | rd_n;
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hrp_pkg::*;
#(
    parameter int    SYNC_STAGES  = 2,
    parameter int    SCRATCH_N    = 8,
    parameter byte_t CTRL_MASK    = 8'h0F,
    parameter byte_t ID_VALUE     = 8'hA5,
    parameter byte_t BRIDGE_RESET = 8'h3C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic [3:0]  addr,
    input  logic [7:0]  din,
    input  logic        din_par,
    output logic [7:0]  dout,
    output logic        dout_par,
    output logic        dout_oe,
    output logic        par_gen,
    output logic        par_gen_oe
);
    logic                      wr_commit;
    addr_t                     hold_addr;
    entry_t                    hold_entry;
    logic [SLOT_N-1:0]         we_vec;
    entry_t                    rd_entry;
    logic [SLOT_N*ENTRY_W-1:0] store_flat;

    hrp_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .din        (din),
        .din_par    (din_par),
        .commit     (wr_commit),
        .hold_addr  (hold_addr),
        .hold_entry (hold_entry)
    );

    hrp_wr_decode u_dec (
        .commit    (wr_commit),
        .hold_addr (hold_addr),
        .we_vec    (we_vec)
    );

    hrp_regfile #(
        .SCRATCH_N    (SCRATCH_N),
        .CTRL_MASK    (CTRL_MASK),
        .ID_VALUE     (ID_VALUE),
        .BRIDGE_RESET (BRIDGE_RESET)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_vec     (we_vec),
        .wr_entry   (hold_entry),
        .rd_addr    (addr),
        .rd_entry   (rd_entry),
        .store_flat (store_flat)
    );

    hrp_bus_drive u_drv (
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .din        (din),
        .rd_entry   (rd_entry),
        .dout       (dout),
        .dout_par   (dout_par),
        .dout_oe    (dout_oe),
        .par_gen    (par_gen),
        .par_gen_oe (par_gen_oe)
    );
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker
    import hrp_pkg::*;
#(
    parameter int    SCRATCH_N = 8,
    parameter byte_t CTRL_MASK = 8'h0F
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic [DATA_W-1:0]         dout,
    input logic                      dout_oe,
    input logic                      par_gen_oe,
    input logic                      wr_commit,
    input logic [SLOT_N*ENTRY_W-1:0] store_flat
);
    localparam addr_t CTRL_ADDR = addr_t'(SCRATCH_N);

    // R3: storage only moves in the cycle after a commit
    a_r3_store_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(store_flat));

    // R3: one commit per strobe release
    a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R7: masked bits of the control slot read as zero
    a_r7_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && addr == CTRL_ADDR) |-> ((dout & ~CTRL_MASK) == '0));

    // R8: exactly one of the two enables is on
    a_r8_enable_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({dout_oe, par_gen_oe}));

    for (genvar i = SCRATCH_N + 1; i < SLOT_N; i++) begin : g_fixed
        if (i == SLOT_N - 1) begin : g_brg
            // R4: the all-ones slot is never loaded
            a_r4_top_slot_fixed: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> $stable(store_flat[i*ENTRY_W +: ENTRY_W]));
        end else begin : g_ro
            // R6: read-only and unmapped slots never change
            a_r6_ro_slot_fixed: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> $stable(store_flat[i*ENTRY_W +: ENTRY_W]));
        end
    end
endmodule

bind hostreg_port hrp_checker #(
    .SCRATCH_N (SCRATCH_N),
    .CTRL_MASK (CTRL_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .par_gen_oe (par_gen_oe),
    .wr_commit  (wr_commit),
    .store_flat (store_flat)
);

// File: tb/hostreg_port_bench.sv
module hostreg_port_bench;
    localparam logic [7:0] ID_VAL   = 8'hA5;
    localparam logic [7:0] BRG_VAL  = 8'h3C;
    localparam logic [7:0] CTRL_MSK = 8'h0F;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, wr_n, rd_n;
    logic [3:0] addr;
    logic [7:0] din;
    logic       din_par;
    logic [7:0] dout;
    logic       dout_par, dout_oe, par_gen, par_gen_oe;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    logic [7:0] exp_d [16];
    logic       exp_p [16];

    always #2 clk = ~clk;

    hostreg_port u_hostreg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .din(din), .din_par(din_par), .dout(dout),
        .dout_par(dout_par), .dout_oe(dout_oe), .par_gen(par_gen),
        .par_gen_oe(par_gen_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d, input logic p);
        if (a < 4'd8) begin
            exp_d[a] = d;
            exp_p[a] = p;
        end else if (a == 4'd8) begin
            exp_d[a] = d & CTRL_MSK;
            exp_p[a] = ~^(d & CTRL_MSK);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d, input logic p,
                              input bit selected);
        @(negedge clk);
        addr = a; din = d; din_par = p; cs_n = !selected; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [7:0] d, output logic p,
                             output logic oe, output logic poe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d = dout; p = dout_par; oe = dout_oe; poe = par_gen_oe;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        logic p, oe, poe;
        for (int i = 0; i < 16; i++) begin
            host_read(4'(i), d, p, oe, poe);
            check(req, $sformatf("slot %0d data", i), {8'h0, d}, {8'h0, exp_d[i]});
            check(req, $sformatf("slot %0d parity", i), {15'h0, p}, {15'h0, exp_p[i]});
            check("R5", "dout_oe during read", {15'h0, oe}, 16'h1);
            check("R8", "par_gen_oe during read", {15'h0, poe}, 16'h0);
        end
    endtask

    task automatic t_reset();
        #1;
        check("R5", "dout_oe idle", {15'h0, dout_oe}, 16'h0);
        check("R8", "par_gen_oe idle", {15'h0, par_gen_oe}, 16'h1);
        check_all("R1");
    endtask

    task automatic t_scratch();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            logic pv;
            v  = 8'(8'h1D * (i + 1)) ^ 8'h5A;
            pv = (i % 3) == 1;
            host_write(4'(i), v, pv, 1'b1);
            model_write(4'(i), v, pv);
        end
        check_all("R9");
    endtask

    task automatic t_commit_vs_read();
        logic [7:0] old_v, new_v;
        old_v = exp_d[2];
        new_v = ~old_v;
        @(negedge clk);
        addr = 4'd2; din = new_v; din_par = 1'b0; cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R3", "old value after 2nd edge", {8'h0, dout}, {8'h0, old_v});
        check("R5", "dout_oe while reading", {15'h0, dout_oe}, 16'h1);
        @(posedge clk);
        #1;
        check("R3", "new value after 3rd edge", {8'h0, dout}, {8'h0, new_v});
        check("R9", "written parity after commit", {15'h0, dout_par}, 16'h0);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        model_write(4'd2, new_v, 1'b0);
    endtask

    task automatic t_cs_gate();
        host_write(4'd3, 8'hC3, 1'b1, 1'b0);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; addr = 4'd3;
        #1;
        check("R2", "dout_oe with cs_n high", {15'h0, dout_oe}, 16'h0);
        check("R8", "par_gen_oe with cs_n high", {15'h0, par_gen_oe}, 16'h1);
        @(negedge clk);
        rd_n = 1'b1;
        check_all("R2");
    endtask

    task automatic t_top_slot();
        host_write(4'hF, 8'hFF, 1'b0, 1'b1);
        host_write(4'hF, 8'h00, 1'b1, 1'b1);
        check_all("R4");
    endtask

    task automatic t_read_only();
        host_write(4'd9, 8'h00, 1'b0, 1'b1);
        host_write(4'd12, 8'hFF, 1'b0, 1'b1);
        host_write(4'd14, 8'h81, 1'b1, 1'b1);
        check_all("R6");
    endtask

    task automatic t_ctrl_mask();
        logic [7:0] d;
        logic p, oe, poe;
        host_write(4'd8, 8'hFF, 1'b0, 1'b1);
        model_write(4'd8, 8'hFF, 1'b0);
        host_read(4'd8, d, p, oe, poe);
        check("R7", "ctrl reads 0F", {8'h0, d}, 16'h000F);
        check("R9", "ctrl parity of 0F", {15'h0, p}, 16'h1);
        host_write(4'd8, 8'hB6, 1'b1, 1'b1);
        model_write(4'd8, 8'hB6, 1'b1);
        host_read(4'd8, d, p, oe, poe);
        check("R7", "ctrl reads 06", {8'h0, d}, 16'h0006);
        check("R9", "ctrl parity of 06", {15'h0, p}, 16'h1);
        check_all("R7");
    endtask

    task automatic t_parity_gen();
        logic [7:0] pats [6];
        pats = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h7E, 8'h13};
        foreach (pats[k]) begin
            @(negedge clk);
            cs_n = 1'b1; din = pats[k];
            #1;
            check("R8", $sformatf("par_gen for %h", pats[k]), {15'h0, par_gen},
                  {15'h0, ~^pats[k]});
            check("R8", "par_gen_oe idle", {15'h0, par_gen_oe}, 16'h1);
        end
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        addr = '0; din = '0; din_par = 1'b0;
        for (int i = 0; i < 16; i++) begin
            exp_d[i] = 8'h00;
            exp_p[i] = 1'b1;
        end
        exp_d[9]  = ID_VAL;  exp_p[9]  = ~^ID_VAL;
        exp_d[15] = BRG_VAL; exp_p[15] = ~^BRG_VAL;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_parity_gen();
        t_scratch();
        t_commit_vs_read();
        t_cs_gate();
        t_top_slot();
        t_read_only();
        t_ctrl_mask();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule